// File: doc/BRIEF.md
# Harvard-Split Memory Strobe Decoder

This block sits between a processor with separate program and data strobes and the external memory banks. Its inputs are a 16-bit address and three active-low strobes: data read, data write and code fetch. It drives an active-low chip select, output enable and write enable for each of three banks: data RAM, code EPROM and a shared upper region.

A mode input picks one of two maps. With the mode low, the whole address space is data RAM, and only the data strobes matter. With the mode high, the map splits:

- The lower half holds RAM that serves data cycles only.
- 0x2000 to 0x7FFF also holds an EPROM that serves code fetches only.
- The upper half is shared. Either a data read or a code fetch enables it, so in that half the processor sees one unified memory.

Code fetches below 0x2000 belong to on-chip ROM and reach no external bank.

The decode is combinational. An optional output register adds one cycle of latency. In split mode a code fetch takes precedence over any data strobe that is active at the same time, so only one bank ever drives the bus.

Top module: `hsd_strobe_dec`

## Requirements
- R1: With split_mode=0, bank 0 (RAM) is selected at every address. Its chip select is active when a data read or a data write is active, its output enable follows the data read and its write enable follows the data write. Bank 1 (EPROM) and bank 2 (shared) stay inactive.
- R2: With split_mode=0, the code-fetch strobe has no effect on any output.
- R3: With split_mode=1, bank 0 responds to a data read (output enable and chip select) and to a data write (write enable and chip select) only for addresses 0x0000 to 0x7FFF.
- R4: With split_mode=1, bank 1 chip select and output enable are active only for a code fetch at 0x2000 to 0x7FFF. Bank 1 write enable is never active.
- R5: With split_mode=1, for addresses 0x8000 to 0xFFFF the bank 2 output enable is active when a data read or a code fetch is active. Its write enable follows the data write, and its chip select is active whenever either of those is.
- R6: With split_mode=1, a code fetch below 0x2000 activates no output.
- R7: With split_mode=1, while a code fetch is active the data-read and data-write strobes are ignored. No write enable is active, and only the fetch decode drives the output enables.
- R8: At most one bank's output enable is active at any time.
- R9: A bank's output enable or write enable is never active without that bank's chip select.
- R10: With REG_OUT=1, the outputs show the decode of the inputs one clock later, and reset forces all outputs high (inactive). With REG_OUT=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | 0 = RAM-only map, 1 = RAM/EPROM/shared map |
| addr | input | 16 | Processor address |
| rd_n | input | 1 | Data-read strobe, active low |
| wr_n | input | 1 | Data-write strobe, active low |
| fetch_n | input | 1 | Code-fetch strobe, active low |
| cs_n | output | 3 | Chip selects, bit 0 RAM, bit 1 EPROM, bit 2 shared |
| oe_n | output | 3 | Output enables, same bank order |
| we_n | output | 3 | Write enables, same bank order |

## Verification
A code fetch and a data access can be presented in the same cycle, and in the upper half both target the shared bank. The sweep drives every combination of the three strobes at every probed address in both modes, including the fetch-plus-read and fetch-plus-write overlaps. It judges each combination against a bench model of the precedence rule: the fetch decode alone survives, no write enable appears, and no two output enables are active together.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int unsigned NBANK = 3;

  typedef enum logic [1:0] {
    BANK_RAM = 2'd0,
    BANK_ROM = 2'd1,
    BANK_SHR = 2'd2
  } bank_e;

  // qualified strobes, active high
  typedef struct packed {
    logic rd;
    logic wr;
    logic fetch;
  } strb_t;

  // per-bank controls, active high
  typedef struct packed {
    logic [NBANK-1:0] cs;
    logic [NBANK-1:0] oe;
    logic [NBANK-1:0] we;
  } ctl_t;
endpackage

// File: rtl/hsd_region.sv
module hsd_region #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h2000,
  parameter logic [ADDR_W-1:0] SHR_BASE = 16'h8000
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     split,
  output logic [hsd_pkg::NBANK-1:0] hit
);
  import hsd_pkg::*;

  logic in_low;
  logic in_rom;

  always_comb begin
    in_low = (addr < SHR_BASE);
    in_rom = in_low && (addr >= ROM_BASE);
    hit = '0;
    hit[int'(BANK_RAM)] = split ? in_low : 1'b1;
    hit[int'(BANK_ROM)] = split & in_rom;
    hit[int'(BANK_SHR)] = split & ~in_low;
  end
endmodule

// File: rtl/hsd_strobe_qual.sv
module hsd_strobe_qual (
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            fetch_n,
  input  logic            split,
  output hsd_pkg::strb_t  q
);
  logic fetch_act;

  always_comb begin
    // the fetch strobe only matters in the split map; there it wins
    fetch_act = split & ~fetch_n;
    q.fetch   = fetch_act;
    q.rd      = ~rd_n & ~fetch_act;
    q.wr      = ~wr_n & ~fetch_act;
  end
endmodule

// File: rtl/hsd_bank_gate.sv
module hsd_bank_gate #(
  parameter bit OE_ON_RD    = 1'b1,
  parameter bit OE_ON_FETCH = 1'b0,
  parameter bit WE_ON_WR    = 1'b1
) (
  input  logic           hit,
  input  hsd_pkg::strb_t q,
  output logic           cs,
  output logic           oe,
  output logic           we
);
  always_comb begin
    oe = hit & ((OE_ON_RD & q.rd) | (OE_ON_FETCH & q.fetch));
    we = hit & WE_ON_WR & q.wr;
    cs = oe | we;
  end
endmodule

// File: rtl/hsd_out_stage.sv
module hsd_out_stage #(
  parameter int unsigned W   = 9,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_n
);
  generate
    if (REG) begin : g_reg
      logic [W-1:0] r_q;
      logic [W-1:0] r_nxt;

      always_comb r_nxt = d;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_nxt;
      end

      assign q_n = ~r_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_n = ~d;
    end
  endgenerate
endmodule

// File: rtl/hsd_strobe_dec.sv
module hsd_strobe_dec #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h2000,
  parameter logic [ADDR_W-1:0] SHR_BASE = 16'h8000,
  parameter bit                REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              fetch_n,
  output logic [2:0]        cs_n,
  output logic [2:0]        oe_n,
  output logic [2:0]        we_n
);
  import hsd_pkg::*;

  localparam int unsigned CW = 3 * NBANK;
  // per-bank strobe usage, bit index = bank number
  localparam logic [NBANK-1:0] OE_RD_M    = 3'b101;
  localparam logic [NBANK-1:0] OE_FETCH_M = 3'b110;
  localparam logic [NBANK-1:0] WE_WR_M    = 3'b101;

  logic             rst_q_n;
  logic [NBANK-1:0] hit;
  strb_t            qs;
  ctl_t             ctl;
  logic [CW-1:0]    out_n;

  // reset: asynchronous assert, synchronous release
  generate
    if (REG_OUT) begin : g_rsync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], 1'b1};
      end
      assign rst_q_n = sync_q[1];
    end else begin : g_rdirect
      assign rst_q_n = rst_n;
    end
  endgenerate

  hsd_region #(
    .ADDR_W  (ADDR_W),
    .ROM_BASE(ROM_BASE),
    .SHR_BASE(SHR_BASE)
  ) u_region (
    .addr (addr),
    .split(split_mode),
    .hit  (hit)
  );

  hsd_strobe_qual u_qual (
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .fetch_n(fetch_n),
    .split  (split_mode),
    .q      (qs)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      hsd_bank_gate #(
        .OE_ON_RD   (OE_RD_M[b]),
        .OE_ON_FETCH(OE_FETCH_M[b]),
        .WE_ON_WR   (WE_WR_M[b])
      ) u_gate (
        .hit(hit[b]),
        .q  (qs),
        .cs (ctl.cs[b]),
        .oe (ctl.oe[b]),
        .we (ctl.we[b])
      );
    end
  endgenerate

  hsd_out_stage #(
    .W  (CW),
    .REG(REG_OUT)
  ) u_out (
    .clk  (clk),
    .rst_n(rst_q_n),
    .d    (ctl),
    .q_n  (out_n)
  );

  assign cs_n = out_n[3*NBANK-1:2*NBANK];
  assign oe_n = out_n[2*NBANK-1:NBANK];
  assign we_n = out_n[NBANK-1:0];
endmodule

// File: rtl/hsd_chk.sv
module hsd_chk #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h2000,
  parameter logic [ADDR_W-1:0] SHR_BASE = 16'h8000,
  parameter bit                LAT      = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              split_mode,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_n,
  input logic              wr_n,
  input logic              fetch_n,
  input logic [2:0]        cs_n,
  input logic [2:0]        oe_n,
  input logic [2:0]        we_n
);
  logic              sp_d;
  logic [ADDR_W-1:0] a_d;
  logic              rd_d, wr_d, f_d;

  generate
    if (LAT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sp_d <= 1'b0;
          a_d  <= '0;
          rd_d <= 1'b1;
          wr_d <= 1'b1;
          f_d  <= 1'b1;
        end else begin
          sp_d <= split_mode;
          a_d  <= addr;
          rd_d <= rd_n;
          wr_d <= wr_n;
          f_d  <= fetch_n;
        end
      end
    end else begin : g_now
      assign sp_d = split_mode;
      assign a_d  = addr;
      assign rd_d = rd_n;
      assign wr_d = wr_n;
      assign f_d  = fetch_n;
    end
  endgenerate

  AST_RAMONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_d |-> (cs_n[1] && cs_n[2] && oe_n[1] && oe_n[2])) else $error("ramonly"); // R1
  AST_RAMONLY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_d && !rd_d) |-> !oe_n[0]) else $error("ramonly rd"); // R2
  AST_LOW_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_d && a_d >= SHR_BASE) |-> (cs_n[0] && cs_n[1])) else $error("upper"); // R3
  AST_ROM_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_d) |-> we_n[1]) else $error("rom we"); // R4
  AST_SHR_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_d && a_d >= SHR_BASE && (!rd_d || !f_d)) |-> !oe_n[2]) else $error("shr oe"); // R5
  AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_d && !f_d && a_d < ROM_BASE) |-> (&cs_n && &oe_n && &we_n)) else $error("onchip"); // R6
  AST_FETCH_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_d && !f_d) |-> &we_n) else $error("fetch we"); // R7
  AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~oe_n)) else $error("oe onehot"); // R8
  AST_CS_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (((~oe_n) | (~we_n)) & cs_n) == 3'b000) else $error("cs cover"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_d && wr_d && f_d) |-> (&cs_n)) else $error("idle"); // R10
endmodule

bind hsd_strobe_dec hsd_chk #(
  .ADDR_W  (ADDR_W),
  .ROM_BASE(ROM_BASE),
  .SHR_BASE(SHR_BASE),
  .LAT     (REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .split_mode(split_mode),
  .addr      (addr),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .fetch_n   (fetch_n),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n)
);

// File: tb/sim_hsd_strobe_dec.sv
`timescale 1ns/1ps
module sim_hsd_strobe_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        split_mode = 1'b0;
  logic [15:0] addr = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1, fetch_n = 1'b1;
  logic [2:0]  cs0, oe0, we0, cs1, oe1, we1;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  hsd_strobe_dec #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .fetch_n(fetch_n),
    .cs_n(cs0), .oe_n(oe0), .we_n(we0));

  hsd_strobe_dec #(.REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .fetch_n(fetch_n),
    .cs_n(cs1), .oe_n(oe1), .we_n(we1));

  // bench model from the requirements: returns {cs_n, oe_n, we_n}
  function automatic logic [8:0] model(input logic sp, input logic [15:0] a,
                                       input logic r_n, input logic w_n, input logic f_n);
    logic r, w, f, lo, rom;
    logic [2:0] cs, oe, we;
    cs = '0; oe = '0; we = '0;
    if (!sp) begin
      oe[0] = !r_n;
      we[0] = !w_n;
    end else begin
      f   = !f_n;
      r   = !r_n && !f;
      w   = !w_n && !f;
      lo  = a < 16'h8000;
      rom = lo && a >= 16'h2000;
      oe[0] = lo && r;
      we[0] = lo && w;
      oe[1] = rom && f;
      oe[2] = !lo && (r || f);
      we[2] = !lo && w;
    end
    cs = oe | we;
    return ~{cs, oe, we};
  endfunction

  function automatic string tag_of(input logic sp, input logic [15:0] a,
                                   input logic r_n, input logic w_n, input logic f_n);
    if (!sp) return f_n ? "R1" : "R2";
    if (!f_n && (!r_n || !w_n)) return "R7";
    if (!f_n && a < 16'h2000) return "R6";
    if (a >= 16'h8000) return "R5";
    if (!f_n) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s addr=%h sp=%b strb=%b%b%b got=%b exp=%b",
               tag, addr, split_mode, rd_n, wr_n, fetch_n, got, exp);
    end
  endtask

  task automatic apply(input logic sp, input logic [15:0] a, input logic [2:0] s);
    logic [8:0] e;
    @(negedge clk);
    split_mode = sp; addr = a; rd_n = s[2]; wr_n = s[1]; fetch_n = s[0];
    e = model(sp, a, s[2], s[1], s[0]);
    @(posedge clk); #1;
    chk(tag_of(sp, a, s[2], s[1], s[0]), {cs1, oe1, we1}, e);
    chk("R10", {cs0, oe0, we0}, e);
    chk("R8", {8'd0, $countones(~oe1) > 1}, 9'd0);
    chk("R9", {6'd0, ((~oe1) | (~we1)) & cs1}, 9'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] bnd [6];
    bnd[0] = 16'h0000; bnd[1] = 16'h1FFF; bnd[2] = 16'h2000;
    bnd[3] = 16'h7FFF; bnd[4] = 16'h8000; bnd[5] = 16'hFFFF;

    repeat (2) @(posedge clk);
    #1;
    chk("R10", {cs0, oe0, we0}, 9'h1FF); // reset state
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10 latency: combinational copy reacts before the edge, registered after
    @(negedge clk);
    split_mode = 1'b1; addr = 16'h0100; rd_n = 1'b0; wr_n = 1'b1; fetch_n = 1'b1;
    #1;
    chk("R10", {cs1, oe1, we1}, ~{3'b001, 3'b001, 3'b000});
    chk("R10", {cs0, oe0, we0}, 9'h1FF);
    @(posedge clk); #1;
    chk("R10", {cs0, oe0, we0}, ~{3'b001, 3'b001, 3'b000});

    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 64; i++) begin
        for (int s = 0; s < 8; s++)
          apply(m[0], 16'(i * 1024 + ((i * 37) & 10'h3FF)), 3'(s));
      end
      for (int k = 0; k < 6; k++) begin
        for (int s = 0; s < 8; s++)
          apply(m[0], bnd[k], 3'(s));
      end
    end

    // R10: asynchronous reset forces the registered outputs inactive
    @(negedge clk);
    split_mode = 1'b1; addr = 16'h9000; rd_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b0; #1;
    chk("R10", {cs0, oe0, we0}, 9'h1FF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule